// File: doc/BRIEF.md
# Dual-Alias Secured SRAM Bank Decoder

This block sits between one request port on the bus side and four SRAM banks of equal size. The four banks lie back to back and form one contiguous region. The region can be reached through two address windows. The window at 0x2000_0000 serves Non-secure traffic and the window at 0x3000_0000 serves Secure traffic. Both windows reach the same physical banks in the same order. Each incoming request carries a security attribute, and the block classifies every request in one of three ways. A request outside both 16MB windows is left unclaimed. A request inside a window whose attribute does not match that window is rejected, and so is a request that lands in the reserved space above the four banks. Every other request goes on to an external protection check.

For a request that passes classification, the block holds a query to the protection checker until the checker answers. On a grant, the block pulses the enable of exactly one bank for one cycle and presents the bank-local word offset together with the write controls. The response goes out in the following cycle and carries the read data of that bank. On a rejection or a denial, the block returns a one-cycle error response, with no bank enable and with the read data at zero. The block holds only one request at a time. Its ready output is high only while it is idle.

Top module: `sram_alias_decoder`

## Requirements
- R1: After a granted check, exactly one bit of `bank_en` goes high for exactly one cycle. The bank index is address bits [16:15] (bank 0 sits at the window base and bank 3 at base+0x1_8000). `bank_offset` is address bits [14:2].
- R2: The Secure window at 0x3000_0000–0x3001_FFFF reaches the same four physical banks in the same order as the Non-secure window, so data written through one window can be read through the other.
- R3: A Secure request (`req_secure`=1) to 0x2000_0000–0x20FF_FFFF returns an error response and never raises `prot_query_valid` or any `bank_en`.
- R4: A Non-secure request (`req_secure`=0) to 0x3000_0000–0x30FF_FFFF returns an error response and never raises `prot_query_valid` or any `bank_en`.
- R5: Requests to 0x2002_0000–0x20FF_FFFF or 0x3002_0000–0x30FF_FFFF return an error response whatever their attribute, and never reach a query or a bank.
- R6: For a request that passes classification, `prot_query_valid` rises in the cycle after acceptance. `prot_query_offset` (address bits [16:0]) and `prot_query_secure` stay stable until `prot_reply_valid`. A bank is enabled only in the cycle after a reply with `prot_reply_grant`=1.
- R7: A reply with `prot_reply_grant`=0 produces, in the next cycle, a one-cycle response with `resp_error`=1 and `resp_rdata`=0, and no bank enable. The addressed location is left unchanged.
- R8: A rejected request (R3–R5) produces `resp_valid`=`resp_error`=1 in the cycle right after acceptance, for one cycle, with `resp_rdata`=0.
- R9: `req_ready` is high only in the idle state. It goes low from the acceptance of a claimed request until the cycle after its response.
- R10: A request outside both 16MB windows produces no response, no query and no bank enable, and `req_ready` stays high.
- R11: The response to a granted request comes in the cycle after the bank enable, with `resp_error`=0. For a read, `resp_rdata` is the selected bank's `bank_rdata` slice. For a write, `bank_we`=1 and `bank_wdata` are driven with the enable, and `resp_rdata`=0. `resp_rdata` is 0 whenever `resp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 32 | Byte address of the request |
| req_secure | input | 1 | Security attribute, 1 = Secure |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| prot_query_valid | output | 1 | Protection check pending |
| prot_query_offset | output | 17 | Byte offset of the request inside the bank region |
| prot_query_secure | output | 1 | Security attribute of the pending check |
| prot_reply_valid | input | 1 | Protection checker answers |
| prot_reply_grant | input | 1 | 1 = access allowed |
| bank_en | output | 4 | One-hot bank enable |
| bank_we | output | 1 | Write enable for the enabled bank |
| bank_offset | output | 13 | Word offset inside the bank |
| bank_wdata | output | 32 | Write data to the bank |
| bank_rdata | input | 128 | Read data of all banks, bank n at bits [32n+31:32n], valid one cycle after enable |
| resp_valid | output | 1 | Response strobe |
| resp_error | output | 1 | Response is an error |
| resp_rdata | output | 32 | Read data of the response |

## Verification
The bench targets the window edges: the last word of bank 3, the first reserved word just above the banks, the top word of each 16MB window, and addresses one byte outside a window. A decoder that compared too few upper bits would claim foreign addresses or leak reserved space into bank 0. It mixes attributes across the two windows. A design that checked only the window and not the attribute would let a mismatched request reach a bank, and one that swapped the bank order between windows would fail the cross-window readback. It delays the protection reply by several cycles and also denies it, so a query that drops early, a bank enabled without a grant, or a denied write that still modifies memory shows up as a wrong enable or wrong read data.

// File: rtl/sad_pkg.sv
package sad_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CHECK  = 3'd1,
        ST_ACCESS = 3'd2,
        ST_RESP   = 3'd3,
        ST_ERR    = 3'd4
    } sad_state_e;

    typedef enum logic [1:0] {
        CL_NONE   = 2'd0,
        CL_REJECT = 2'd1,
        CL_PASS   = 2'd2
    } sad_class_e;

endpackage

// File: rtl/sad_addr_decode.sv
module sad_addr_decode
    import sad_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int WIN_AW    = 24,
    parameter int REGION_AW = 17,
    parameter logic [ADDR_W-1:0] NS_BASE = 32'h2000_0000,
    parameter logic [ADDR_W-1:0] S_BASE  = 32'h3000_0000
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 secure,
    output sad_class_e           cls,
    output logic [REGION_AW-1:0] region_off
);
    logic hit_ns;
    logic hit_s;
    logic in_banks;

    always_comb begin
        hit_ns     = (addr[ADDR_W-1:WIN_AW] == NS_BASE[ADDR_W-1:WIN_AW]);
        hit_s      = (addr[ADDR_W-1:WIN_AW] == S_BASE[ADDR_W-1:WIN_AW]);
        in_banks   = (addr[WIN_AW-1:REGION_AW] == '0);
        region_off = addr[REGION_AW-1:0];
        if (!hit_ns && !hit_s) begin
            cls = CL_NONE;
        end else if (!in_banks) begin
            cls = CL_REJECT;
        end else if (hit_ns && secure) begin
            cls = CL_REJECT;
        end else if (hit_s && !secure) begin
            cls = CL_REJECT;
        end else begin
            cls = CL_PASS;
        end
    end
endmodule

// File: rtl/sad_bank_select.sv
module sad_bank_select #(
    parameter int BANKS  = 4,
    parameter int DATA_W = 32,
    localparam int SEL_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic                    active,
    input  logic [SEL_W-1:0]        sel,
    input  logic [BANKS*DATA_W-1:0] rdata_all,
    output logic [BANKS-1:0]        en,
    output logic [DATA_W-1:0]       rdata
);
    for (genvar g = 0; g < BANKS; g++) begin : g_en
        assign en[g] = active && (sel == SEL_W'(g));
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < BANKS; i++) begin
            if (sel == SEL_W'(i)) begin
                rdata = rdata_all[i*DATA_W +: DATA_W];
            end
        end
    end
endmodule

// File: rtl/sram_alias_decoder.sv
module sram_alias_decoder
    import sad_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int BANKS      = 4,
    parameter int BANK_BYTES = 32768,
    parameter int WIN_BYTES  = 16777216,
    parameter logic [ADDR_W-1:0] NS_BASE = 32'h2000_0000,
    parameter logic [ADDR_W-1:0] S_BASE  = 32'h3000_0000,
    localparam int SEL_W     = (BANKS > 1) ? $clog2(BANKS) : 1,
    localparam int BANK_AW   = $clog2(BANK_BYTES),
    localparam int REGION_AW = BANK_AW + SEL_W,
    localparam int WIN_AW    = $clog2(WIN_BYTES),
    localparam int BYTE_AW   = $clog2(DATA_W / 8),
    localparam int OFF_W     = BANK_AW - BYTE_AW
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic                    req_secure,
    input  logic                    req_write,
    input  logic [DATA_W-1:0]       req_wdata,
    output logic                    prot_query_valid,
    output logic [REGION_AW-1:0]    prot_query_offset,
    output logic                    prot_query_secure,
    input  logic                    prot_reply_valid,
    input  logic                    prot_reply_grant,
    output logic [BANKS-1:0]        bank_en,
    output logic                    bank_we,
    output logic [OFF_W-1:0]        bank_offset,
    output logic [DATA_W-1:0]       bank_wdata,
    input  logic [BANKS*DATA_W-1:0] bank_rdata,
    output logic                    resp_valid,
    output logic                    resp_error,
    output logic [DATA_W-1:0]       resp_rdata
);
    typedef struct packed {
        sad_state_e           st;
        logic [REGION_AW-1:0] off;
        logic                 sec;
        logic                 we;
        logic [DATA_W-1:0]    wdata;
    } ctx_t;

    localparam ctx_t CTX_RESET = '{st: ST_IDLE, off: '0, sec: 1'b0, we: 1'b0, wdata: '0};

    ctx_t                 ctx_d;
    ctx_t                 ctx_q;
    sad_class_e           cls;
    logic [REGION_AW-1:0] dec_off;
    logic                 access_active;
    logic [DATA_W-1:0]    sel_rdata;

    sad_addr_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_AW   (WIN_AW),
        .REGION_AW(REGION_AW),
        .NS_BASE  (NS_BASE),
        .S_BASE   (S_BASE)
    ) u_dec (
        .addr      (req_addr),
        .secure    (req_secure),
        .cls       (cls),
        .region_off(dec_off)
    );

    sad_bank_select #(
        .BANKS (BANKS),
        .DATA_W(DATA_W)
    ) u_sel (
        .active   (access_active),
        .sel      (ctx_q.off[REGION_AW-1:BANK_AW]),
        .rdata_all(bank_rdata),
        .en       (bank_en),
        .rdata    (sel_rdata)
    );

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (cls == CL_PASS) begin
                        ctx_d.st    = ST_CHECK;
                        ctx_d.off   = dec_off;
                        ctx_d.sec   = req_secure;
                        ctx_d.we    = req_write;
                        ctx_d.wdata = req_wdata;
                    end else if (cls == CL_REJECT) begin
                        ctx_d.st = ST_ERR;
                    end
                end
            end
            ST_CHECK: begin
                if (prot_reply_valid) begin
                    ctx_d.st = prot_reply_grant ? ST_ACCESS : ST_ERR;
                end
            end
            ST_ACCESS: ctx_d.st = ST_RESP;
            ST_RESP:   ctx_d.st = ST_IDLE;
            ST_ERR:    ctx_d.st = ST_IDLE;
            default:   ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= CTX_RESET;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    always_comb begin
        access_active     = (ctx_q.st == ST_ACCESS);
        req_ready         = (ctx_q.st == ST_IDLE);
        prot_query_valid  = (ctx_q.st == ST_CHECK);
        prot_query_offset = ctx_q.off;
        prot_query_secure = ctx_q.sec;
        bank_we           = access_active && ctx_q.we;
        bank_offset       = ctx_q.off[BANK_AW-1:BYTE_AW];
        bank_wdata        = access_active ? ctx_q.wdata : '0;
        resp_valid        = (ctx_q.st == ST_RESP) || (ctx_q.st == ST_ERR);
        resp_error        = (ctx_q.st == ST_ERR);
        resp_rdata        = ((ctx_q.st == ST_RESP) && !ctx_q.we) ? sel_rdata : '0;
    end
endmodule

// File: rtl/sad_checker.sv
module sad_checker #(
    parameter int BANKS     = 4,
    parameter int DATA_W    = 32,
    parameter int REGION_AW = 17
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_ready,
    input logic                 prot_query_valid,
    input logic [REGION_AW-1:0] prot_query_offset,
    input logic                 prot_query_secure,
    input logic                 prot_reply_valid,
    input logic                 prot_reply_grant,
    input logic [BANKS-1:0]     bank_en,
    input logic                 resp_valid,
    input logic                 resp_error,
    input logic [DATA_W-1:0]    resp_rdata
);
    AST_BANK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_en)); // R1
    AST_BANK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_en != '0) |=> (bank_en == '0)); // R1
    AST_EN_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_en != '0) |-> $past(prot_reply_valid && prot_reply_grant && prot_query_valid)); // R6
    AST_QUERY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_query_valid && !prot_reply_valid) |=> (prot_query_valid && $stable(prot_query_offset) && $stable(prot_query_secure))); // R6
    AST_ERR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_error) |-> (bank_en == '0 && resp_rdata == '0)); // R7
    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid); // R8
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_query_valid || bank_en != '0 || resp_valid) |-> !req_ready); // R9
    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> (resp_rdata == '0)); // R11
endmodule

bind sram_alias_decoder sad_checker #(
    .BANKS    (BANKS),
    .DATA_W   (DATA_W),
    .REGION_AW(REGION_AW)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .req_ready        (req_ready),
    .prot_query_valid (prot_query_valid),
    .prot_query_offset(prot_query_offset),
    .prot_query_secure(prot_query_secure),
    .prot_reply_valid (prot_reply_valid),
    .prot_reply_grant (prot_reply_grant),
    .bank_en          (bank_en),
    .resp_valid       (resp_valid),
    .resp_error       (resp_error),
    .resp_rdata       (resp_rdata)
);

// File: tb/sim_sram_alias_decoder.sv
`timescale 1ns/1ps
module sim_sram_alias_decoder;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_addr = '0;
    logic         req_secure = 1'b0;
    logic         req_write = 1'b0;
    logic [31:0]  req_wdata = '0;
    logic         prot_query_valid;
    logic [16:0]  prot_query_offset;
    logic         prot_query_secure;
    logic         prot_reply_valid = 1'b0;
    logic         prot_reply_grant = 1'b0;
    logic [3:0]   bank_en;
    logic         bank_we;
    logic [12:0]  bank_offset;
    logic [31:0]  bank_wdata;
    logic [127:0] bank_rdata = '0;
    logic         resp_valid;
    logic         resp_error;
    logic [31:0]  resp_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    // expected outputs after the next rising edge
    bit          e_ready, e_qv, e_qsec, e_rv, e_re, e_we;
    logic [16:0] e_qoff;
    logic [3:0]  e_en;
    logic [12:0] e_off;
    logic [31:0] e_wdata, e_rdata;
    string       tag;

    logic [31:0] sram [int];   // bench bank storage
    logic [31:0] ref_mem [int]; // reference contents

    always #2.5 clk = ~clk;

    sram_alias_decoder u0 (.*);

    // behavioural SRAM: read data one cycle after enable
    always @(posedge clk) begin
        for (int b = 0; b < 4; b++) begin
            if (bank_en[b]) begin
                if (bank_we) sram[b*8192 + int'(bank_offset)] = bank_wdata;
                else bank_rdata[b*32 +: 32] <= sram.exists(b*8192 + int'(bank_offset)) ?
                                               sram[b*8192 + int'(bank_offset)] : 32'h0;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles exp < 20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h exp %h (t=%0t)", req, what, got, exp, $time);
        end
    endtask

    task automatic set_idle();
        e_ready = 1; e_qv = 0; e_qsec = 0; e_rv = 0; e_re = 0; e_we = 0;
        e_qoff = '0; e_en = '0; e_off = '0; e_wdata = '0; e_rdata = '0;
    endtask

    // advance one cycle and compare every observable output
    task automatic step();
        @(negedge clk);
        chk("R9", "req_ready", 32'(req_ready), 32'(e_ready));
        chk(tag, "resp_valid", 32'(resp_valid), 32'(e_rv));
        chk(tag, "resp_error", 32'(resp_error), 32'(e_re));
        chk("R11", "resp_rdata", resp_rdata, e_rdata);
        chk("R6", "prot_query_valid", 32'(prot_query_valid), 32'(e_qv));
        chk("R1", "bank_en", 32'(bank_en), 32'(e_en));
        if (e_qv) begin
            chk("R6", "prot_query_offset", 32'(prot_query_offset), 32'(e_qoff));
            chk("R6", "prot_query_secure", 32'(prot_query_secure), 32'(e_qsec));
        end
        if (e_en != '0) begin
            chk("R1", "bank_offset", 32'(bank_offset), 32'(e_off));
            chk("R11", "bank_we", 32'(bank_we), 32'(e_we));
            if (e_we) chk("R11", "bank_wdata", bank_wdata, e_wdata);
        end
    endtask

    // one transaction: grant=0 denies; delay = cycles before the reply
    task automatic txn(string req, logic [31:0] a, bit sec, bit wr, logic [31:0] wd,
                       bit grant, int delay);
        bit in_win, in_banks, match;
        int key;
        tag = req;
        in_win   = (a[31:24] == 8'h20) || (a[31:24] == 8'h30);
        in_banks = (a[23:17] == 7'h0);
        match    = (a[31:24] == 8'h20) ? !sec : sec;
        key      = int'(a[16:15]) * 8192 + int'(a[14:2]);
        req_valid = 1; req_addr = a; req_secure = sec; req_write = wr; req_wdata = wd;
        set_idle();
        if (!in_win) begin                    // R10
            step();
            req_valid = 0;
            step();
            return;
        end
        e_ready = 0;
        if (!in_banks || !match) begin        // R3 R4 R5 R8
            e_rv = 1; e_re = 1;
            step();
            req_valid = 0;
            set_idle();
            step();
            return;
        end
        e_qv = 1; e_qoff = a[16:0]; e_qsec = sec;
        step();
        req_valid = 0;
        for (int i = 0; i < delay; i++) step();
        prot_reply_valid = 1; prot_reply_grant = grant;
        e_qv = 0;
        if (!grant) begin                     // R7
            e_rv = 1; e_re = 1;
            step();
            prot_reply_valid = 0; prot_reply_grant = 0;
            set_idle();
            step();
            return;
        end
        e_en = 4'b0001 << a[16:15]; e_off = a[14:2]; e_we = wr; e_wdata = wd;
        step();
        prot_reply_valid = 0; prot_reply_grant = 0;
        e_en = '0;
        e_rv = 1; e_re = 0;
        if (wr) ref_mem[key] = wd;
        e_rdata = wr ? 32'h0 : (ref_mem.exists(key) ? ref_mem[key] : 32'h0);
        step();
        set_idle();
        step();
    endtask

    initial begin
        tag = "R9";
        set_idle();
        #12;
        @(negedge clk);
        // reset state
        chk("R9", "reset req_ready", 32'(req_ready), 32'd1);
        chk("R11", "reset resp_valid", 32'(resp_valid), 32'd0);
        chk("R1", "reset bank_en", 32'(bank_en), 32'd0);
        rst_n = 1;
        step();
        // R1 R11: non-secure write and read of bank 0
        txn("R1", 32'h2000_0010, 0, 1, 32'hA5A5_0001, 1, 0);
        txn("R11", 32'h2000_0010, 0, 0, 32'h0, 1, 0);
        // R2: same location through the secure window
        txn("R2", 32'h3000_0010, 1, 0, 32'h0, 1, 2);
        // R1: last word of bank 3, written secure, read non-secure (R2)
        txn("R1", 32'h3001_FFFC, 1, 1, 32'hDEAD_BEEF, 1, 3);
        txn("R2", 32'h2001_FFFC, 0, 0, 32'h0, 1, 1);
        // banks 1 and 2
        txn("R1", 32'h3000_8000, 1, 1, 32'h1111_2222, 1, 0);
        txn("R1", 32'h2001_0004, 0, 1, 32'h3333_4444, 1, 0);
        txn("R2", 32'h2000_8000, 0, 0, 32'h0, 1, 0);
        txn("R2", 32'h3001_0004, 1, 0, 32'h0, 1, 4);
        // R3: secure access to non-secure window
        txn("R3", 32'h2000_0010, 1, 1, 32'hBAD0_0003, 1, 0);
        // R4: non-secure access to secure window
        txn("R4", 32'h3001_0004, 0, 1, 32'hBAD0_0004, 1, 0);
        // R5: reserved space, both windows, both attributes
        txn("R5", 32'h2002_0000, 0, 0, 32'h0, 1, 0);
        txn("R5", 32'h30FF_FFFC, 1, 1, 32'hBAD0_0005, 1, 0);
        txn("R5", 32'h3002_0000, 1, 0, 32'h0, 1, 0);
        // R7: denied write leaves memory unchanged
        txn("R7", 32'h2000_8000, 0, 1, 32'hBAD0_0007, 0, 2);
        txn("R7", 32'h3000_8000, 1, 0, 32'h0, 1, 0);
        // R3 R4 left data intact
        txn("R3", 32'h3000_0010, 1, 0, 32'h0, 1, 0);
        txn("R4", 32'h2001_0004, 0, 0, 32'h0, 1, 0);
        // R10: outside both windows
        txn("R10", 32'h1FFF_FFFC, 0, 1, 32'hBAD0_0010, 1, 0);
        txn("R10", 32'h2100_0000, 0, 0, 32'h0, 1, 0);
        txn("R10", 32'h4000_0000, 1, 0, 32'h0, 1, 0);
        // R6: long wait, then read the top of bank 3 through the secure window
        txn("R6", 32'h3001_FFFC, 1, 0, 32'h0, 1, 7);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule